// File: doc/BRIEF.md
# Tile Watermark Bit Recovery

This block recovers one hidden watermark bit from a single 3×3 tile of marked 8-bit pixels. It first decides whether the tile is busy or smooth by counting how many of the nine pixels have their top bit set, using the same rule the marking side used. A busy tile carries its bit in a higher bit-plane and a smooth tile in a lower one. The block then reads that plane from all nine pixels and takes a majority vote.

Each tile is presented in one cycle with `valid_in`. One cycle later the block shows the recovered bit, the busy/smooth flag and the number of ones it found in the chosen plane, together with `valid_out`. Splitting an image into tiles and comparing the recovered message with the original are left to the surrounding logic.

Top module: `tile_mark_extract`

## Requirements
- R1: Pixel k (k = 0..8) occupies `tile_in[8k+7:8k]`. The tile is flagged busy (`busy_out` = 1) when the number of pixels with bit 7 set is 4, 5 or 6. For any other count (0–3 or 7–9) the tile is smooth (`busy_out` = 0).
- R2: The carrier plane is bit index 2 of each pixel for a smooth tile and bit index 4 for a busy tile. Bits that are neither bit 7 nor the selected carrier bit have no effect on any output.
- R3: `mark_out` is 1 when more than four of the nine carrier bits are 1, and 0 otherwise.
- R4: `ones_out` equals the number of ones among the nine carrier bits, from 0 to 9.
- R5: The results for a tile appear on the outputs in the cycle after the edge that samples `valid_in` high. `valid_out` is high in exactly those cycles.
- R6: When `valid_in` is low, `mark_out`, `busy_out` and `ones_out` keep their previous values and `valid_out` goes low.
- R7: After reset, `valid_out`, `mark_out`, `busy_out` and `ones_out` are all zero.
- R8: Marking a tile writes bit w into its carrier plane and the inverse of w into the plane just below it. Extracting such a tile returns w for every top-bit count from 0 to 9 and for both values of w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Tile on `tile_in` is to be processed |
| tile_in | input | 72 | Nine packed 8-bit pixels, pixel 0 in the low byte |
| valid_out | output | 1 | Results for a tile are present |
| mark_out | output | 1 | Recovered watermark bit |
| busy_out | output | 1 | 1 = busy tile (carrier bit 4), 0 = smooth (carrier bit 2) |
| ones_out | output | 4 | Count of ones in the carrier plane |

## Verification
The bench walks the top-bit count through all ten values, so a design that placed the busy window one step off, for example 3..5 or 4..7, would report the wrong flag and would read the wrong plane at the edges of the window. In the vote sweep the unused plane is filled with the complement of the carrier, so a design that swapped the two planes returns the inverted bit and the complementary count. Counts of 4 and 5 mark the vote threshold, where a design that used ≥4 or ≥6 gives the wrong answer. A stall with a changed tile catches a design whose output registers load without `valid_in`.

// File: rtl/tile_mark_extract.sv
module tile_mark_extract #(
  parameter int PIX_W      = 8,
  parameter int SMOOTH_PLN = 3,
  parameter int BUSY_PLN   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_in,
  input  logic [9*PIX_W-1:0]   tile_in,
  output logic                 valid_out,
  output logic                 mark_out,
  output logic                 busy_out,
  output logic [3:0]           ones_out
);

  localparam int NPIX     = 9;
  localparam int TOP      = PIX_W - 1;
  localparam int SMOOTH_I = SMOOTH_PLN - 1;
  localparam int BUSY_I   = BUSY_PLN - 1;

  logic [NPIX-1:0] tops, lo_bits, hi_bits, carrier;
  logic [3:0]      top_sum, ones;
  logic            busy;

  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    assign tops[k]    = tile_in[k*PIX_W + TOP];
    assign lo_bits[k] = tile_in[k*PIX_W + SMOOTH_I];
    assign hi_bits[k] = tile_in[k*PIX_W + BUSY_I];
  end

  always_comb begin
    top_sum = '0;
    ones    = '0;
    for (int k = 0; k < NPIX; k++) begin
      top_sum = top_sum + 4'(tops[k]);
      ones    = ones + 4'(carrier[k]);
    end
  end

  assign busy    = (top_sum >= 4'd4) && (top_sum <= 4'd6);
  assign carrier = busy ? hi_bits : lo_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      mark_out  <= 1'b0;
      busy_out  <= 1'b0;
      ones_out  <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        mark_out <= ones > 4'd4;
        busy_out <= busy;
        ones_out <= ones;
      end
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(mark_out) && $stable(busy_out) && $stable(ones_out)));
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    ones_out <= 4'd9);
  a_r3_vote_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (mark_out == (ones_out >= 4'd5)));

endmodule

// File: tb/tile_mark_extract_test.sv
`timescale 1ns/1ps
module tile_mark_extract_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid_in = 0;
  logic [71:0] tile_in = '0;
  logic        valid_out, mark_out, busy_out;
  logic [3:0]  ones_out;
  int vectors = 0;
  int bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  tile_mark_extract uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .tile_in(tile_in),
    .valid_out(valid_out), .mark_out(mark_out), .busy_out(busy_out),
    .ones_out(ones_out)
  );

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[23:16];
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic [71:0] t);
    @(negedge clk);
    tile_in  = t;
    valid_in = 1;
    @(posedge clk);
    #1;
    valid_in = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    logic [71:0] t;
    logic [7:0]  px;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 valid_out", valid_out, 0);
    chk("R7 mark_out", mark_out, 0);
    chk("R7 busy_out", busy_out, 0);
    chk("R7 ones_out", ones_out, 0);
    @(negedge clk);
    rst_n = 1;

    // R8 / R1: mark then extract, every top-bit count, both bit values
    for (int s = 0; s <= 9; s++) begin
      for (int w = 0; w < 2; w++) begin
        for (int rep = 0; rep < 4; rep++) begin
          automatic bit b = (s >= 4 && s <= 6);
          automatic int c = b ? 4 : 2;
          for (int p = 0; p < 9; p++) begin
            px = rnd();
            px[7] = (p < s);
            px[c] = w[0];
            px[c-1] = ~w[0];
            t[p*8 +: 8] = px;
          end
          apply(t);
          chk("R5 valid_out", valid_out, 1);
          chk("R8 mark_out roundtrip", mark_out, w);
          chk("R1 busy_out", busy_out, b);
          chk("R4 ones_out roundtrip", ones_out, w ? 9 : 0);
        end
      end
    end

    // R2 / R3 / R4: vote sweep, unused plane complemented
    for (int k = 0; k <= 9; k++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 9; p++) begin
          px = rnd();
          px[7] = m ? (p < 5) : 1'b0;
          px[m ? 4 : 2] = (p < k);
          px[m ? 2 : 4] = !(p < k);
          t[p*8 +: 8] = px;
        end
        apply(t);
        chk("R2 busy_out mode", busy_out, m);
        chk("R4 ones_out", ones_out, k);
        chk("R3 mark_out vote", mark_out, k > 4);
      end
    end

    // R6: stall with changed tile, outputs hold
    for (int p = 0; p < 9; p++) t[p*8 +: 8] = 8'h04;
    apply(t);
    chk("R3 setup mark", mark_out, 1);
    @(negedge clk);
    tile_in = '0;
    valid_in = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R6 valid_out low", valid_out, 0);
    chk("R6 mark_out hold", mark_out, 1);
    chk("R6 busy_out hold", busy_out, 0);
    chk("R6 ones_out hold", ones_out, 9);

    // R5: back-to-back tiles
    @(negedge clk);
    tile_in = {9{8'h04}};
    valid_in = 1;
    @(posedge clk); #1;
    chk("R5 first of pair", ones_out, 9);
    @(negedge clk);
    tile_in = {9{8'h00}};
    @(posedge clk); #1;
    valid_in = 0;
    chk("R5 second of pair", ones_out, 0);
    chk("R5 valid pair", valid_out, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule